// File: doc/BRIEF.md
# Accumulator ALU with Z/N/H/C flags

This block is the purely combinational arithmetic and logic stage of a small accumulator-based processor. A 4-bit operation select picks one function. The accumulator, a second operand and the current flag nibble come in. The block returns an 8-bit result, a flag byte and a result write-enable. The surrounding core fetches operands, holds the registers and decodes instructions. It writes `res_out` back to the accumulator, or to the register that supplied the operand, when `res_we` is high. It always latches `flags_out` as the new flag byte.

Besides the usual binary operations, the unit produces a half-carry flag from the low nibble. It also performs a decimal-adjust step that corrects a packed-BCD sum or difference. That step reads the incoming subtract flag to learn whether the previous operation was an addition or a subtraction. The block holds no state and has no clock: it has no state register and no transitions, and every output follows its inputs within the same cycle.

Top module: `accalu`

## Requirements
- R1: Op 0 (add) and op 1 (add with carry, which adds the incoming C) return `acc_in + opnd_in (+C)` modulo 256. They set Z when that result is zero, clear N, set H on a carry out of bit 3 and set C on a carry out of bit 7. `res_we` is 1.
- R2: Op 2 (subtract) and op 3 (subtract with borrow, which also subtracts the incoming C) return `acc_in - opnd_in (-C)` modulo 256. They set N and set Z on a zero result. H is set on a borrow out of the low nibble. C is set when the subtrahend plus any borrow exceeds `acc_in`. `res_we` is 1.
- R3: Op 4 (compare) sets Z, N, H and C exactly as op 2 would. It drives `res_out` equal to `acc_in` and holds `res_we` at 0.
- R4: Op 5 (AND) sets H to 1 and clears N and C. Op 6 (OR) and op 7 (XOR) clear N, H and C. All three set Z from the result and have `res_we` equal to 1.
- R5: Op 8 (complement) returns the bitwise inverse of `acc_in` and sets N and H. Z and C are unchanged and `res_we` is 1.
- R6: Op 9 (increment) and op 10 (decrement) act on `opnd_in`. They set Z from the result and leave C unchanged. Increment clears N and sets H when the low nibble carries. Decrement sets N and sets H when the low nibble borrows. `res_we` is 1.
- R7: Op 11 sets C and op 12 inverts C. Both clear N and H, leave Z unchanged, return `acc_in` and hold `res_we` at 0.
- R8: Op 13 (decimal adjust) with incoming N clear builds an adjustment and adds it to `acc_in`. The adjustment gets 0x06 if H is set or the low nibble of `acc_in` exceeds 9. It gets 0x60 if C is set or `acc_in` exceeds 0x99, and in that case C is set; otherwise C is unchanged.
- R9: Op 13 with incoming N set subtracts an adjustment of 0x06 (if H) plus 0x60 (if C) from `acc_in` and leaves C unchanged. In both decimal-adjust cases H is cleared, N is unchanged, Z comes from the adjusted result and `res_we` is 1.
- R10: Ops 14 and 15 return `acc_in`, hold `res_we` at 0 and leave all four flags unchanged.
- R11: `flags_in` carries Z at bit 3, N at bit 2, H at bit 1 and C at bit 0. `flags_out` carries Z at bit 7, N at bit 6, H at bit 5 and C at bit 4, and its bits 3 to 0 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation select, encoded as in R1 to R10 |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand; the subject of increment and decrement |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| res_out | output | 8 | Operation result |
| flags_out | output | 8 | Updated flag byte {Z,N,H,C,0000} |
| res_we | output | 1 | High when the result must be written back |

## Verification
Because the unit is stateless, any defect shows at the ports in the same cycle that the faulty operation is presented. Nothing is hidden behind a later access. A wrong nibble carry, a misplaced flag bit or a flag that should have been preserved shows up as a mismatched flag byte on that very operation. Carry-preservation and decimal-adjust errors need operands at the nibble and byte boundaries, combined with both values of the incoming carry and subtract flags. The bench therefore drives those boundaries directly, then sweeps every operation over arbitrary operands and flags against an independent reference model.

// File: rtl/accalu_pkg.sv
package accalu_pkg;
    localparam int DW = 8;
    localparam int NW = DW / 2;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_NOT = 4'd8,
        OP_INC = 4'd9,
        OP_DEC = 4'd10,
        OP_STC = 4'd11,
        OP_CMC = 4'd12,
        OP_BCD = 4'd13
    } op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flg_t;
endpackage

// File: rtl/accalu_addsub.sv
module accalu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         hout
);
    localparam int HW = W / 2;

    logic [W:0]  wide;
    logic [HW:0] nib;

    always_comb begin
        if (sub) begin
            wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
            nib  = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]} - {{HW{1'b0}}, cin};
        end else begin
            wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            nib  = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
        end
        res  = wide[W-1:0];
        cout = wide[W];
        hout = nib[HW];
    end
endmodule

// File: rtl/accalu_logic.sv
module accalu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   fn,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (fn)
            2'd0:    res = a & b;
            2'd1:    res = a | b;
            2'd2:    res = a ^ b;
            default: res = ~a;
        endcase
    end
endmodule

// File: rtl/accalu_daa.sv
module accalu_daa (
    input  logic [7:0] a,
    input  logic       n_in,
    input  logic       h_in,
    input  logic       c_in,
    output logic [7:0] res,
    output logic       c_out
);
    logic [7:0] adj;
    logic       hi_fix;

    always_comb begin
        adj    = 8'h00;
        hi_fix = 1'b0;
        if (n_in) begin
            if (h_in) adj = adj + 8'h06;
            if (c_in) adj = adj + 8'h60;
            res   = a - adj;
            c_out = c_in;
        end else begin
            if (h_in || (a[3:0] > 4'd9)) adj = adj + 8'h06;
            hi_fix = c_in || (a > 8'h99);
            if (hi_fix) adj = adj + 8'h60;
            res   = a + adj;
            c_out = hi_fix;
        end
    end
endmodule

// File: rtl/accalu.sv
module accalu
    import accalu_pkg::*;
(
    input  logic [3:0]    op_sel,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] opnd_in,
    input  logic [3:0]    flags_in,
    output logic [DW-1:0] res_out,
    output logic [DW-1:0] flags_out,
    output logic          res_we
);
    flg_t          fi;
    flg_t          fo;
    logic [DW-1:0] as_res;
    logic          as_c;
    logic          as_h;
    logic          as_sub;
    logic          as_cin;
    logic [DW-1:0] st_res;
    logic          st_c;
    logic          st_h;
    logic [DW-1:0] lg_res;
    logic [1:0]    lg_fn;
    logic [DW-1:0] bcd_res;
    logic          bcd_c;
    op_e           op;

    assign fi     = flg_t'(flags_in);
    assign op     = op_e'(op_sel);
    assign as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
    assign as_cin = ((op == OP_ADC) || (op == OP_SBC)) ? fi.c : 1'b0;
    assign lg_fn  = (op == OP_AND) ? 2'd0 :
                    (op == OP_OR)  ? 2'd1 :
                    (op == OP_XOR) ? 2'd2 : 2'd3;

    accalu_addsub #(.W(DW)) main_u (
        .a(acc_in), .b(opnd_in), .cin(as_cin), .sub(as_sub),
        .res(as_res), .cout(as_c), .hout(as_h)
    );

    accalu_addsub #(.W(DW)) step_u (
        .a(opnd_in), .b({DW{1'b0}}), .cin(1'b1), .sub(op == OP_DEC),
        .res(st_res), .cout(st_c), .hout(st_h)
    );

    accalu_logic #(.W(DW)) logic_u (
        .a(acc_in), .b(opnd_in), .fn(lg_fn), .res(lg_res)
    );

    accalu_daa bcd_u (
        .a(acc_in), .n_in(fi.n), .h_in(fi.h), .c_in(fi.c),
        .res(bcd_res), .c_out(bcd_c)
    );

    always_comb begin
        res_out = acc_in;
        fo      = fi;
        res_we  = 1'b0;
        unique case (op_sel)
            OP_ADD, OP_ADC: begin
                res_out = as_res;
                fo      = '{z: (as_res == '0), n: 1'b0, h: as_h, c: as_c};
                res_we  = 1'b1;
            end
            OP_SUB, OP_SBC: begin
                res_out = as_res;
                fo      = '{z: (as_res == '0), n: 1'b1, h: as_h, c: as_c};
                res_we  = 1'b1;
            end
            OP_CMP: begin
                fo      = '{z: (as_res == '0), n: 1'b1, h: as_h, c: as_c};
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_out = lg_res;
                fo      = '{z: (lg_res == '0), n: 1'b0, h: (op == OP_AND), c: 1'b0};
                res_we  = 1'b1;
            end
            OP_NOT: begin
                res_out = lg_res;
                fo.n    = 1'b1;
                fo.h    = 1'b1;
                res_we  = 1'b1;
            end
            OP_INC, OP_DEC: begin
                res_out = st_res;
                fo      = '{z: (st_res == '0), n: (op == OP_DEC), h: st_h, c: fi.c};
                res_we  = 1'b1;
            end
            OP_STC, OP_CMC: begin
                fo      = '{z: fi.z, n: 1'b0, h: 1'b0,
                            c: (op == OP_STC) ? 1'b1 : ~fi.c};
            end
            OP_BCD: begin
                res_out = bcd_res;
                fo      = '{z: (bcd_res == '0), n: fi.n, h: 1'b0, c: bcd_c};
                res_we  = 1'b1;
            end
            default: begin
                res_out = acc_in;
                fo      = fi;
                res_we  = 1'b0;
            end
        endcase
    end

    assign flags_out = {fo, {NW{1'b0}}};

    logic unused_c;
    assign unused_c = st_c;
endmodule

// File: rtl/accalu_chk.sv
module accalu_chk (
    input logic [3:0] op_sel,
    input logic [7:0] acc_in,
    input logic [7:0] opnd_in,
    input logic [3:0] flags_in,
    input logic [7:0] res_out,
    input logic [7:0] flags_out,
    input logic       res_we
);
    always_comb begin
        // R11
        flag_nibble_chk: assert (flags_out[3:0] == 4'h0)
            else $error("flag byte low nibble not zero");
        // R3
        if (op_sel == 4'd4) begin
            cmp_nowrite_chk: assert (!res_we && res_out == acc_in)
                else $error("compare wrote a result");
        end
        // R6
        if (op_sel == 4'd9 || op_sel == 4'd10) begin
            step_carry_chk: assert (flags_out[4] == flags_in[0])
                else $error("inc/dec altered carry");
        end
        // R4
        if (op_sel == 4'd5) begin
            and_flags_chk: assert (flags_out[6:4] == 3'b010 && flags_out[7] == (res_out == 8'h00))
                else $error("and flags wrong");
        end
        // R7
        if (op_sel == 4'd11) begin
            stc_flags_chk: assert (flags_out[6:4] == 3'b001 && flags_out[7] == flags_in[3])
                else $error("set-carry flags wrong");
        end
        // R10
        if (op_sel >= 4'd14) begin
            idle_pass_chk: assert (!res_we && res_out == acc_in && flags_out[7:4] == flags_in)
                else $error("unused code not transparent");
        end
        // R1
        if (op_sel == 4'd0) begin
            add_low_chk: assert (res_out[3:0] == 4'(acc_in[3:0] + opnd_in[3:0]))
                else $error("add low nibble wrong");
        end
    end
endmodule

bind accalu accalu_chk chk_i (.*);

// File: tb/accalu_tb_top.sv
module accalu_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_sel = 4'd15;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] opnd_in = 8'h00;
    logic [3:0] flags_in = 4'h0;
    logic [7:0] res_out;
    logic [7:0] flags_out;
    logic       res_we;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [16:0] exp_v;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    accalu dut_i (
        .op_sel(op_sel), .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
        .res_out(res_out), .flags_out(flags_out), .res_we(res_we)
    );

    function automatic string req_of(input int op);
        case (op)
            0, 1:    return "R1";
            2, 3:    return "R2";
            4:       return "R3";
            5, 6, 7: return "R4";
            8:       return "R5";
            9, 10:   return "R6";
            11, 12:  return "R7";
            13:      return "R8/R9";
            default: return "R10";
        endcase
    endfunction

    // reference model: returns {res[7:0], flags[7:0], we}
    function automatic logic [16:0] model(input int op, input int a, input int b, input int f);
        int z = (f >> 3) & 1, n = (f >> 2) & 1, h = (f >> 1) & 1, c = f & 1;
        int r = a, we = 0, t, adj;
        case (op)
            0, 1: begin
                t = (op == 1) ? c : 0;
                h = (((a & 15) + (b & 15) + t) > 15) ? 1 : 0;
                c = ((a + b + t) > 255) ? 1 : 0;
                r = (a + b + t) & 255; n = 0; z = (r == 0); we = 1;
            end
            2, 3, 4: begin
                t = (op == 3) ? c : 0;
                h = ((a & 15) < ((b & 15) + t)) ? 1 : 0;
                c = (a < (b + t)) ? 1 : 0;
                t = (a - b - t) & 255; n = 1; z = (t == 0);
                if (op != 4) begin r = t; we = 1; end
            end
            5, 6, 7: begin
                r = (op == 5) ? (a & b) : (op == 6) ? (a | b) : (a ^ b);
                z = (r == 0); n = 0; h = (op == 5); c = 0; we = 1;
            end
            8: begin r = 255 - a; n = 1; h = 1; we = 1; end
            9: begin r = (b + 1) & 255; z = (r == 0); n = 0; h = ((b & 15) == 15); we = 1; end
            10: begin r = (b + 255) & 255; z = (r == 0); n = 1; h = ((b & 15) == 0); we = 1; end
            11: begin n = 0; h = 0; c = 1; end
            12: begin n = 0; h = 0; c = 1 - c; end
            13: begin
                adj = 0;
                if (n == 1) begin
                    if (h == 1) adj += 6;
                    if (c == 1) adj += 96;
                    r = (a - adj) & 255;
                end else begin
                    if (h == 1 || (a & 15) > 9) adj += 6;
                    if (c == 1 || a > 153) begin adj += 96; c = 1; end
                    r = (a + adj) & 255;
                end
                h = 0; z = (r == 0); we = 1;
            end
            default: ;
        endcase
        model = {8'(r), 1'(z), 1'(n), 1'(h), 1'(c), 4'h0, 1'(we)};
    endfunction

    task automatic drive(input int op, input int a, input int b, input int f, input string note);
        item_t it;
        @(posedge clk);
        op_sel   <= 4'(op);
        acc_in   <= 8'(a);
        opnd_in  <= 8'(b);
        flags_in <= 4'(f);
        it.exp_v = model(op, a, b, f);
        it.tag   = {req_of(op), " ", note};
        exp_q.push_back(it);
    endtask

    // monitor: compare away from the driving edge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                total++;
                if ({res_out, flags_out, res_we} !== it.exp_v) begin
                    bad++;
                    $display("FAIL %s op=%0d: got res=%02h flg=%02h we=%0b exp res=%02h flg=%02h we=%0b",
                             it.tag, op_sel, res_out, flags_out, res_we,
                             it.exp_v[16:9], it.exp_v[8:1], it.exp_v[0]);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        drive(15, 0, 0, 0, "R11 reset-time idle code");
        rst = 1'b0;
        drive(0, 8'h0F, 8'h01, 0, "R1 half carry");
        drive(0, 8'hFF, 8'h01, 0, "R1 wrap to zero");
        drive(1, 8'h0E, 8'h01, 1, "R1 adc carry in");
        drive(2, 8'h10, 8'h01, 0, "R2 nibble borrow");
        drive(3, 8'h00, 8'h00, 1, "R2 sbc borrow only");
        drive(4, 8'h42, 8'h42, 0, "R3 compare equal");
        drive(4, 8'h10, 8'h20, 0, "R3 compare less");
        drive(5, 8'hF0, 8'h0F, 15, "R4 and zero");
        drive(7, 8'hAA, 8'hAA, 15, "R4 xor self");
        drive(8, 8'h5A, 8'h00, 9, "R5 complement");
        drive(9, 0, 8'hFF, 1, "R6 inc wrap keeps C");
        drive(10, 0, 8'h01, 0, "R6 dec to zero");
        drive(10, 0, 8'h10, 1, "R6 dec nibble borrow");
        drive(11, 0, 0, 8, "R7 set carry");
        drive(12, 0, 0, 7, "R7 invert carry");
        drive(13, 8'h7D, 0, 0, "R8 low fix");
        drive(13, 8'h9A, 0, 0, "R8 both fixes to zero");
        drive(13, 8'h12, 0, 1, "R8 carry in forces high fix");
        drive(13, 8'h0C, 0, 4'b0110, "R9 subtract low fix");
        drive(13, 8'h33, 0, 4'b0101, "R9 subtract high fix keeps C");
        drive(14, 8'h77, 8'h11, 15, "R10 code 14");
        drive(15, 8'h88, 8'h22, 5, "R10 code 15");
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 60; k++) begin
                drive(op, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                      int'($urandom_range(0, 15)), "R11 sweep");
            end
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule